// File: doc/BRIEF.md
# Peripheral Clock and Reset Restart Sequencer

This block restarts a peripheral through a system controller. A single-cycle request on `start_i` launches a fixed four-step sequence. Each step fires one strobe towards the system controller and then watches one status bit until that bit reaches the level the step expects.

The steps run in a fixed order. First the reset is put on and the sequencer waits for the reset status to read 1. Next the clock is gated off and it waits for the clock status to read 0. Then the reset is taken off and it waits for the reset status to read 0. Last the clock is turned back on and it waits for the clock status to read 1.

A strobe is a request to write 1 to a control location. In the system controller, each gating-off or reset-release location sits 4 bytes above its partner. The sequencer drives the four strobes as separate pins, so that byte layout belongs to the system controller and does not appear here. Every wait is bounded by `POLL_LIMIT` polls. If a step times out, the sequence stops, the later steps never fire, and an error flag is held. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `rstclk_seq`

## Requirements
- R1: While reset is applied, and after it is released, every strobe, `done_o` and `err_o` are 0 and the sequencer is idle.
- R2: A high `start_i` sampled while idle starts a sequence, and `rst_on_o` is high in the very next cycle.
- R3: The strobes fire in this order: `rst_on_o` (waits for `rst_stat_i`=1), `clk_off_o` (waits for `clk_stat_i`=0), `rst_off_o` (waits for `rst_stat_i`=0), `clk_on_o` (waits for `clk_stat_i`=1).
- R4: Each strobe is high for exactly one cycle, and at most one strobe is high in any cycle.
- R5: Polling begins in the cycle after a strobe, one poll per cycle. If the expected level is first seen in poll cycle n (n ≥ 1), the next strobe, or `done_o` after the last step, is high in cycle n+1 counted from the strobe.
- R6: A step that finds the expected level in its `POLL_LIMIT`-th poll succeeds. A step that does not find it in `POLL_LIMIT` polls raises `err_o` in cycle `POLL_LIMIT`+1 after its strobe, and no further strobe fires.
- R7: `done_o` is a one-cycle pulse that follows a successful fourth step. It is never high in a sequence that ends in error.
- R8: `err_o` stays high until the next accepted start and falls in the cycle after that start is sampled.
- R9: A high `start_i` while a sequence is running is ignored: it adds no strobe, does not restart the sequence, and does not change the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the restart sequence |
| rst_stat_i | input | 1 | Reset status readback (1 = peripheral held in reset) |
| clk_stat_i | input | 1 | Clock status readback (1 = peripheral clock running) |
| rst_on_o | output | 1 | Strobe: put the reset on |
| clk_off_o | output | 1 | Strobe: gate the clock off |
| rst_off_o | output | 1 | Strobe: take the reset off |
| clk_on_o | output | 1 | Strobe: turn the clock on |
| done_o | output | 1 | One-cycle pulse when all four steps succeed |
| err_o | output | 1 | Held high after a step times out |

## Verification
The bench covers several status cases: a status that is already at its target when polling starts, status delays that differ from step to step, a status that arrives in the last allowed poll, and one that arrives a poll too late.

An off-by-one error in the poll counter shows up in two ways. The last-poll case would fail when it should pass, or the late case would pass when it should fail; either way, the scoreboard sees `err_o` or the next strobe in the wrong cycle. Timeouts are forced at the first, second and fourth steps. A sequencer that kept running after a timeout would emit strobes the scoreboard does not expect. One that also pulsed `done_o` after a timeout would be caught the same way.

A second start in the middle of a run would show up as a repeated reset strobe or as shifted timing. An error flag that clears early would fail the hold check made before the next run.

// File: rtl/rstclk_seq_pkg.sv
package rstclk_seq_pkg;
  localparam int NSTEPS = 4;
  localparam int STEP_W = $clog2(NSTEPS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_POLL  = 2'd2
  } seq_state_e;

  // Step order: 0 reset on, 1 clock off, 2 reset off, 3 clock on.
  // Even steps watch the reset status, odd steps watch the clock status.
  function automatic logic step_uses_clk(input logic [STEP_W-1:0] s);
    return s[0];
  endfunction

  // Target level: 1 for steps 0 and 3, 0 for steps 1 and 2.
  function automatic logic step_target(input logic [STEP_W-1:0] s);
    return ~(s[0] ^ s[1]);
  endfunction
endpackage

// File: rtl/rstclk_poll_timer.sv
module rstclk_poll_timer #(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic count_i,
  output logic last_o
);
  localparam int CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (count_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/rstclk_step_decode.sv
module rstclk_step_decode
  import rstclk_seq_pkg::*;
(
  input  logic              pulse_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              rst_stat_i,
  input  logic              clk_stat_i,
  output logic [NSTEPS-1:0] strobe_o,
  output logic              match_o
);
  for (genvar g = 0; g < NSTEPS; g++) begin : g_strobe
    assign strobe_o[g] = pulse_i && (step_i == STEP_W'(g));
  end

  logic watched;
  assign watched = step_uses_clk(step_i) ? clk_stat_i : rst_stat_i;
  assign match_o = (watched == step_target(step_i));
endmodule

// File: rtl/rstclk_step_fsm.sv
module rstclk_step_fsm
  import rstclk_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              match_i,
  input  logic              last_poll_i,
  output logic              pulse_o,
  output logic              polling_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [STEP_W-1:0] FINAL = STEP_W'(NSTEPS - 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PULSE;
          step_q  <= '0;
          err_q   <= 1'b0;
        end
        ST_PULSE: state_q <= ST_POLL;
        ST_POLL: begin
          if (match_i) begin
            if (step_q == FINAL) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= ST_PULSE;
            end
          end else if (last_poll_i) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse_o   = (state_q == ST_PULSE);
  assign polling_o = (state_q == ST_POLL);
  assign step_o    = step_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/rstclk_seq.sv
module rstclk_seq
  import rstclk_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rst_stat_i,
  input  logic clk_stat_i,
  output logic rst_on_o,
  output logic clk_off_o,
  output logic rst_off_o,
  output logic clk_on_o,
  output logic done_o,
  output logic err_o
);
  logic              pulse, polling, match, last_poll;
  logic [STEP_W-1:0] step;
  logic [NSTEPS-1:0] strobe;

  rstclk_step_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .match_i(match),
    .last_poll_i(last_poll), .pulse_o(pulse), .polling_o(polling),
    .step_o(step), .done_o(done_o), .err_o(err_o)
  );

  rstclk_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(pulse), .count_i(polling),
    .last_o(last_poll)
  );

  rstclk_step_decode u_dec (
    .pulse_i(pulse), .step_i(step), .rst_stat_i(rst_stat_i),
    .clk_stat_i(clk_stat_i), .strobe_o(strobe), .match_o(match)
  );

  assign rst_on_o  = strobe[0];
  assign clk_off_o = strobe[1];
  assign rst_off_o = strobe[2];
  assign clk_on_o  = strobe[3];
endmodule

// File: rtl/rstclk_seq_chk.sv
module rstclk_seq_chk #(
  parameter int POLL_LIMIT = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic rst_on_o,
  input logic clk_off_o,
  input logic rst_off_o,
  input logic clk_on_o,
  input logic done_o,
  input logic err_o
);
  localparam int WW = $clog2(POLL_LIMIT + 3);
  localparam logic [WW-1:0] WMAX = WW'(POLL_LIMIT + 2);

  logic [3:0]    stb;
  logic [WW-1:0] wait_q;

  assign stb = {clk_on_o, rst_off_o, clk_off_o, rst_on_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wait_q <= '0;
    else if (|stb)         wait_q <= '0;
    else if (wait_q != WMAX) wait_q <= wait_q + 1'b1;
  end

  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |=> !(|(stb & $past(stb))));
  // R2
  first_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_on_o) |-> $past(start_i));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> err_o);
  // R6
  err_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (wait_q >= WW'(POLL_LIMIT)));
  // R6
  no_strobe_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !start_i) |=> !(|stb));
endmodule

bind rstclk_seq rstclk_seq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .rst_on_o(rst_on_o), .clk_off_o(clk_off_o), .rst_off_o(rst_off_o),
  .clk_on_o(clk_on_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/rstclk_seq_tb.sv
module rstclk_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 16;
  localparam int NEVER = 99;

  typedef struct { int kind; int gap; } exp_t; // kind 0..3 strobe, 4 done, 5 error

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rst_stat = 1'b0, clk_stat = 1'b1;
  logic rst_on, clk_off, rst_off, clk_on, done, err;

  int checks = 0, fails = 0, cyc = 0, last_cyc = 0;
  int dly [4];
  int pend = -1, pend_kind = 0;
  logic done_d = 1'b0, err_d = 1'b0;
  exp_t q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstclk_seq #(.POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rst_stat_i(rst_stat),
    .clk_stat_i(clk_stat), .rst_on_o(rst_on), .clk_off_o(clk_off),
    .rst_off_o(rst_off), .clk_on_o(clk_on), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int k);
    case (k)
      0: rst_stat = 1'b1;
      1: clk_stat = 1'b0;
      2: rst_stat = 1'b0;
      default: clk_stat = 1'b1;
    endcase
  endtask

  // Status responder: applies strobe k's effect dly[k] negedges after the strobe.
  always @(negedge clk) begin
    logic [3:0] s;
    s = {clk_on, rst_off, clk_off, rst_on};
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin apply(pend_kind); pend = -1; end
    end
    for (int k = 0; k < 4; k++) if (s[k]) begin
      if (dly[k] == 0) apply(k);
      else if (dly[k] != NEVER) begin pend = dly[k]; pend_kind = k; end
    end
  end

  task automatic event_seen(input int kind);
    exp_t e;
    string tag;
    tag = (kind < 4) ? "R3" : (kind == 4) ? "R7" : "R6";
    if (q.size() == 0) begin
      check(1'b0, {tag, " unexpected event"}, kind, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == kind, {tag, " event order"}, kind, e.kind);
      if (e.gap >= 0) check(cyc - last_cyc == e.gap, "R5/R6 event timing", cyc - last_cyc, e.gap);
    end
    last_cyc = cyc;
  endtask

  // Monitor
  always @(negedge clk) if (rst_n) begin
    logic [3:0] s;
    s = {clk_on, rst_off, clk_off, rst_on};
    if ($countones(s) > 1) check(1'b0, "R4 several strobes", $countones(s), 1);
    for (int k = 0; k < 4; k++) if (s[k]) event_seen(k);
    if (done && !done_d) event_seen(4);
    if (done && done_d) check(1'b0, "R7 done wider than one cycle", 2, 1);
    if (err && !err_d) event_seen(5);
    done_d = done;
    err_d = err;
  end

  task automatic run_seq(input int d0, input int d1, input int d2, input int d3,
                         input int glitch);
    exp_t e;
    int g;
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    pend = -1;
    rst_stat = 1'b0; clk_stat = 1'b1;
    for (int k = 0; k < 4; k++) begin
      e.kind = k;
      e.gap = (k == 0) ? -1 : (((dly[k-1] < 1) ? 1 : dly[k-1]) + 1);
      q.push_back(e);
      if (dly[k] > LIMIT) begin
        e.kind = 5; e.gap = LIMIT + 1; q.push_back(e);
        break;
      end
      if (k == 3) begin
        e.kind = 4; e.gap = ((dly[3] < 1) ? 1 : dly[3]) + 1; q.push_back(e);
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R2 / R8: first strobe now, error cleared
    check(rst_on == 1'b1, "R2 reset-on strobe after start", rst_on, 1);
    check(err == 1'b0, "R8 error cleared by start", err, 0);
    if (glitch > 0) begin
      repeat (glitch) @(negedge clk);
      start = 1'b1; // R9: must be ignored
      @(negedge clk); start = 1'b0;
    end
    g = 0;
    while (q.size() != 0 && g < 400) begin @(negedge clk); g++; end
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R3 missing events", q.size(), 0);
  endtask

  initial begin
    dly[0] = 0; dly[1] = 0; dly[2] = 0; dly[3] = 0;
    repeat (3) @(negedge clk);
    // R1
    check({rst_on, clk_off, rst_off, clk_on, done, err} == 6'b0, "R1 outputs in reset",
          int'({rst_on, clk_off, rst_off, clk_on, done, err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({rst_on, clk_off, rst_off, clk_on, done, err} == 6'b0, "R1 idle after reset",
          int'({rst_on, clk_off, rst_off, clk_on, done, err}), 0);

    run_seq(0, 0, 0, 0, 0);                 // R5 immediate matches
    run_seq(3, 1, 5, 2, 0);                 // R5 mixed delays
    run_seq(2, 4, LIMIT, 1, 0);             // R6 last allowed poll succeeds
    run_seq(1, LIMIT + 1, 0, 0, 0);         // R6 one poll too late fails at step 2
    repeat (20) @(negedge clk);
    check(err == 1'b1, "R8 error held", err, 1);
    run_seq(NEVER, 0, 0, 0, 0);             // R6 timeout at first step
    run_seq(0, 2, 3, NEVER, 0);             // R6/R7 timeout at last step, no done
    run_seq(3, 3, 3, 3, 2);                 // R9 start during run ignored
    run_seq(0, 0, 0, 0, 4);                 // R9 again, different phase
    check(err == 1'b0, "R8 no error after good run", err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule